// File: doc/BRIEF.md
# Interrupt-Controller Indirect Register Window

This block is the software-facing register front end of an I/O interrupt controller with a parameterised number of input pins (24 by default). Software sees only two bus locations: an 8-bit select register and a 32-bit data window. The value in the select register picks which internal register the window reaches. The targets are the controller identity, a read-only version word, an arbitration word, and either half of a 64-bit routing entry kept for every pin.

Each routing entry carries a vector, a delivery mode, a destination mode, a delivery-status flag, an input polarity, a remote-IRR flag, a trigger mode, a mask and a destination. The remote-IRR flag and the delivery-status flag belong to the delivery logic. Software writes never alter them. The delivery logic drives them through per-pin strobes and a status input. All entries are exported in parallel to that logic. A single-cycle pulse, together with the pin number, tells the delivery logic when a software write changes a pin's mask.

Top module: `irqc_regwin`

## Requirements
- R1: A write to bus offset 0x00 stores bits 7:0 of the write data in the select register, and the upper bits are dropped. A read of offset 0x00 returns the stored byte with bits 31:8 zero.
- R2: With select 0x01, a window read returns NPINS-1 in bits 23:16 and the version code (default 0x11) in bits 7:0, with all other bits zero. Window writes at select 0x01 change nothing.
- R3: With select 0x00, a window write stores data bits 27:24 as the 4-bit identity, and a read returns it in bits 27:24 with all other bits zero. With select 0x02, a read returns the same value and a write changes nothing.
- R4: A select value S of 0x10 or above reaches entry (S-0x10)>>1. Odd S reaches entry bits 63:32 and even S reaches bits 31:0. Entry layout: vector 7:0, delivery mode 10:8, destination mode 11, delivery status 12, polarity 13, remote IRR 14, trigger mode 15 (1 = level, 0 = edge), mask 16, destination 63:56. Bits 55:17 are stored as written.
- R5: A window read at a select value that reaches no register (0x03 to 0x0F, or an entry number of NPINS or above) returns 0xFFFFFFFF. A write there changes no state.
- R6: Software writes never change entry bits 14 and 12. Bit 12 is loaded every cycle from hw_dstat. Bit 14 is cleared by hw_rirr_clr and is set by hw_rirr_set only while the stored trigger mode is level.
- R7: Whenever an entry's trigger bit 15 is 0 after a write, its remote-IRR bit 14 is 0.
- R8: After reset, every entry is zero except mask bit 16, which is 1. The select register and the identity are also zero.
- R9: A read strobe at offset 0x00 or 0x10 yields bus_rvalid and the data on the following cycle. Any other offset reads as zero and ignores writes.
- R10: When a window write changes an entry's mask bit, mask_chg_o is high for exactly one cycle, in the cycle after the write, and mask_chg_pin_o carries that pin. In all other cycles mask_chg_o stays low.
- R11: entries_o bits 64*i+63 to 64*i always hold the current contents of entry i, updated in the cycle after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset within the block |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| hw_rirr_set | input | NPINS | Per-pin remote-IRR set strobe from delivery logic |
| hw_rirr_clr | input | NPINS | Per-pin remote-IRR clear strobe (end of interrupt) |
| hw_dstat | input | NPINS | Per-pin delivery-status level from delivery logic |
| entries_o | output | NPINS*64 | All routing entries, entry i in bits 64*i+63 to 64*i |
| mask_chg_o | output | 1 | One-cycle mask-change pulse |
| mask_chg_pin_o | output | PIN_W | Pin whose mask changed |

## Verification
The case that is hardest to reach from the ports is a level-mode entry whose remote-IRR bit is already set by the delivery side when software rewrites it. Two follow-ups matter there. Zeros in bits 14 and 12 of the written data must leave both flags unchanged. A later write that switches the entry to edge mode must clear remote IRR while delivery status survives. The stimulus first programs a pin to level mode, pulses its hw_rirr_set strobe and holds its hw_dstat high, then issues the two rewrites through the select/window pair. A random phase then mixes window writes, select changes, reads and sparse hardware strobes, and a behavioural model is compared against the outputs every clock.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

   // Routing entry, bit positions are software visible
   typedef struct packed {
      logic [7:0]  dest;     // 63:56
      logic [38:0] spare;    // 55:17
      logic        mask;     // 16
      logic        level;    // 15 (1 = level, 0 = edge)
      logic        rirr;     // 14 hardware owned
      logic        pol;      // 13
      logic        dstat;    // 12 hardware owned
      logic        dmode;    // 11
      logic [2:0]  dlv;      // 10:8
      logic [7:0]  vec;      // 7:0
   } redir_t;

   typedef enum logic [2:0] {
      WK_ID,
      WK_VER,
      WK_ARB,
      WK_ENTRY,
      WK_NONE
   } win_kind_e;

   localparam logic [7:0] IDX_ID         = 8'h00;
   localparam logic [7:0] IDX_VER        = 8'h01;
   localparam logic [7:0] IDX_ARB        = 8'h02;
   localparam logic [7:0] IDX_ENTRY_BASE = 8'h10;
   localparam int         ENTRY_W        = 64;

endpackage

// File: rtl/irqc_sel_decode.sv
module irqc_sel_decode
   import irqc_pkg::*;
#(
   parameter int NPINS = 24,
   parameter int PIN_W = $clog2(NPINS)
) (
   input  logic [7:0]       sel,
   output win_kind_e        kind,
   output logic [PIN_W-1:0] pin,
   output logic             hi
);

   logic [6:0] raw_idx;

   always_comb begin
      raw_idx = 7'((sel - IDX_ENTRY_BASE) >> 1);
      pin     = PIN_W'(raw_idx);
      hi      = sel[0];
      if (sel == IDX_ID)
         kind = WK_ID;
      else if (sel == IDX_VER)
         kind = WK_VER;
      else if (sel == IDX_ARB)
         kind = WK_ARB;
      else if ((sel >= IDX_ENTRY_BASE) && (int'(raw_idx) < NPINS))
         kind = WK_ENTRY;
      else
         kind = WK_NONE;
   end

endmodule

// File: rtl/irqc_redir_entry.sv
module irqc_redir_entry
   import irqc_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_lo,
   input  logic        wr_hi,
   input  logic [31:0] wdata,
   input  logic        hw_rirr_set,
   input  logic        hw_rirr_clr,
   input  logic        hw_dstat,
   output redir_t      entry_o,
   output logic        mask_chg_o
);

   localparam redir_t RST_VAL = redir_t'(64'h1 << 16);

   redir_t cur_q;
   redir_t nxt;
   logic   rirr_hw;
   logic   chg_q;

   always_comb begin
      rirr_hw = (cur_q.rirr & ~hw_rirr_clr) | (hw_rirr_set & cur_q.level);
      nxt     = cur_q;
      if (wr_lo)
         nxt = {cur_q[63:32], wdata};
      else if (wr_hi)
         nxt = {wdata, cur_q[31:0]};
      nxt.dstat = hw_dstat;
      // edge mode drops remote IRR
      nxt.rirr  = rirr_hw & nxt.level;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q <= RST_VAL;
         chg_q <= 1'b0;
      end else begin
         cur_q <= nxt;
         chg_q <= (nxt.mask != cur_q.mask);
      end
   end

   assign entry_o    = cur_q;
   assign mask_chg_o = chg_q;

   p_edge_no_rirr_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      !cur_q.level |-> !cur_q.rirr);

   p_rirr_kept_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo && wdata[15] && cur_q.level && !hw_rirr_set && !hw_rirr_clr)
      |=> (cur_q.rirr == $past(cur_q.rirr)));

   p_mask_pulse_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      mask_chg_o |-> (cur_q.mask != $past(cur_q.mask)));

   p_mask_hold_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      !wr_lo |=> $stable(cur_q.mask));

endmodule

// File: rtl/irqc_regwin.sv
module irqc_regwin
   import irqc_pkg::*;
#(
   parameter int              NPINS            = 24,
   parameter int              ADDR_W           = 8,
   parameter logic [ADDR_W-1:0] SEL_OFF        = 'h00,
   parameter logic [ADDR_W-1:0] WIN_OFF        = 'h10,
   parameter logic [7:0]      VERSION          = 8'h11,
   parameter bit              RDATA_CLEAR_IDLE = 1'b0,
   localparam int             PIN_W            = $clog2(NPINS)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      bus_wr,
   input  logic                      bus_rd,
   input  logic [ADDR_W-1:0]         bus_addr,
   input  logic [31:0]               bus_wdata,
   output logic [31:0]               bus_rdata,
   output logic                      bus_rvalid,
   input  logic [NPINS-1:0]          hw_rirr_set,
   input  logic [NPINS-1:0]          hw_rirr_clr,
   input  logic [NPINS-1:0]          hw_dstat,
   output logic [NPINS*ENTRY_W-1:0]  entries_o,
   output logic                      mask_chg_o,
   output logic [PIN_W-1:0]          mask_chg_pin_o
);

   // elaboration checks
   if ((NPINS < 2) || (NPINS > 120)) begin : g_bad_npins
      $error("irqc_regwin: NPINS must lie in 2..120");
   end
   if (SEL_OFF == WIN_OFF) begin : g_bad_offs
      $error("irqc_regwin: select and window offsets must differ");
   end

   logic [7:0]       sel_q;
   logic [3:0]       id_q;
   win_kind_e        kind;
   logic [PIN_W-1:0] pin;
   logic             hi;
   logic             win_wr;
   logic [31:0]      rd_val;
   logic [31:0]      win_val;
   logic [31:0]      rdata_q;
   logic             rvalid_q;
   logic [NPINS-1:0] chg_vec;
   redir_t           ent_arr [NPINS];

   irqc_sel_decode #(.NPINS(NPINS), .PIN_W(PIN_W)) u_dec (
      .sel  (sel_q),
      .kind (kind),
      .pin  (pin),
      .hi   (hi)
   );

   assign win_wr = bus_wr && (bus_addr == WIN_OFF);

   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      logic hit;
      assign hit = win_wr && (kind == WK_ENTRY) && (pin == PIN_W'(i));
      irqc_redir_entry u_ent (
         .clk         (clk),
         .rst_n       (rst_n),
         .wr_lo       (hit && !hi),
         .wr_hi       (hit && hi),
         .wdata       (bus_wdata),
         .hw_rirr_set (hw_rirr_set[i]),
         .hw_rirr_clr (hw_rirr_clr[i]),
         .hw_dstat    (hw_dstat[i]),
         .entry_o     (ent_arr[i]),
         .mask_chg_o  (chg_vec[i])
      );
      assign entries_o[i*ENTRY_W +: ENTRY_W] = ent_arr[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
         id_q  <= '0;
      end else if (bus_wr) begin
         if (bus_addr == SEL_OFF)
            sel_q <= bus_wdata[7:0];
         if (win_wr && (kind == WK_ID))
            id_q <= bus_wdata[27:24];
      end
   end

   always_comb begin
      case (kind)
         WK_ID, WK_ARB: win_val = {4'b0, id_q, 24'b0};
         WK_VER:        win_val = {8'b0, 8'(NPINS - 1), 8'b0, VERSION};
         WK_ENTRY:      win_val = hi ? ent_arr[pin][63:32] : ent_arr[pin][31:0];
         default:       win_val = '1;
      endcase
      if (bus_addr == SEL_OFF)
         rd_val = {24'b0, sel_q};
      else if (bus_addr == WIN_OFF)
         rd_val = win_val;
      else
         rd_val = '0;
   end

   if (RDATA_CLEAR_IDLE) begin : g_rd_clr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rdata_q <= '0;
         else        rdata_q <= bus_rd ? rd_val : '0;
      end
   end else begin : g_rd_hold
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      rdata_q <= '0;
         else if (bus_rd) rdata_q <= rd_val;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rvalid_q <= 1'b0;
      else        rvalid_q <= bus_rd;
   end

   assign bus_rdata  = rdata_q;
   assign bus_rvalid = rvalid_q;
   assign mask_chg_o = |chg_vec;

   always_comb begin
      mask_chg_pin_o = '0;
      for (int k = 0; k < NPINS; k++)
         if (chg_vec[k]) mask_chg_pin_o = PIN_W'(k);
   end

   p_sel_kept_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == SEL_OFF) |=> (sel_q == $past(bus_wdata[7:0])));

   p_id_stable_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      !(win_wr && sel_q == IDX_ID) |=> $stable(id_q));

   p_rvalid_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd |=> bus_rvalid);

   p_rvalid_idle_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> !bus_rvalid);

   p_one_chg_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(chg_vec));

endmodule

// File: tb/irqc_regwin_tb.sv
`timescale 1ns/1ps
module irqc_regwin_tb_top;

   localparam int NP    = 24;
   localparam int PW    = $clog2(NP);
   localparam logic [7:0] SELA = 8'h00;
   localparam logic [7:0] WINA = 8'h10;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0]        bus_addr = '0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic              bus_rvalid;
   logic [NP-1:0]     hw_set = '0, hw_clr = '0, hw_ds = '0;
   logic [NP*64-1:0]  entries;
   logic              mask_chg;
   logic [PW-1:0]     mask_pin;

   int unsigned total = 0;
   int unsigned bad   = 0;

   logic [63:0]   m_ent [NP];
   logic [7:0]    m_sel;
   logic [3:0]    m_id;
   logic [NP-1:0] ds_hold = '0;
   logic [31:0]   last_rd;

   always #2 clk = ~clk;

   irqc_regwin dut_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .bus_wr         (bus_wr),
      .bus_rd         (bus_rd),
      .bus_addr       (bus_addr),
      .bus_wdata      (bus_wdata),
      .bus_rdata      (bus_rdata),
      .bus_rvalid     (bus_rvalid),
      .hw_rirr_set    (hw_set),
      .hw_rirr_clr    (hw_clr),
      .hw_dstat       (hw_ds),
      .entries_o      (entries),
      .mask_chg_o     (mask_chg),
      .mask_chg_pin_o (mask_pin)
   );

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] model_read(input logic [7:0] addr);
      logic [63:0] e;
      if (addr == SELA) return {24'b0, m_sel};
      if (addr != WINA) return 32'h0;
      if (m_sel == 8'h00 || m_sel == 8'h02) return {4'b0, m_id, 24'b0};
      if (m_sel == 8'h01) return ((NP - 1) << 16) | 32'h11;
      if (m_sel >= 8'h10 && int'((m_sel - 8'h10) >> 1) < NP) begin
         e = m_ent[int'((m_sel - 8'h10) >> 1)];
         return m_sel[0] ? e[63:32] : e[31:0];
      end
      return 32'hFFFF_FFFF;
   endfunction

   // one clock: drive at negedge, update model at posedge, check at next negedge
   task automatic step(input logic wr, input logic rd, input logic [7:0] addr, input logic [31:0] wd,
                       input logic [NP-1:0] set, input logic [NP-1:0] clr, input logic [NP-1:0] ds,
                       input string tag);
      logic [31:0] exp_rd;
      logic        exp_chg;
      int          exp_pin;
      logic [63:0] nx [NP];
      logic [7:0]  nsel;
      logic [3:0]  nid;
      bit          ok;
      int          badp;
      bus_wr = wr; bus_rd = rd; bus_addr = addr; bus_wdata = wd;
      hw_set = set; hw_clr = clr; hw_ds = ds;
      exp_rd  = model_read(addr);
      exp_chg = 1'b0; exp_pin = 0;
      nsel = m_sel; nid = m_id;
      for (int p = 0; p < NP; p++) begin
         logic [63:0] o, n;
         logic        r;
         o = m_ent[p]; n = o;
         r = (o[14] & ~clr[p]) | (set[p] & o[15]);
         if (wr && addr == WINA && m_sel >= 8'h10 && int'((m_sel - 8'h10) >> 1) == p) begin
            if (m_sel[0]) n[63:32] = wd;
            else          n[31:0]  = wd;
         end
         n[12] = ds[p];
         n[14] = r & n[15];
         if (n[16] != o[16]) begin exp_chg = 1'b1; exp_pin = p; end
         nx[p] = n;
      end
      if (wr && addr == SELA) nsel = wd[7:0];
      if (wr && addr == WINA && m_sel == 8'h00) nid = wd[27:24];
      @(posedge clk);
      for (int p = 0; p < NP; p++) m_ent[p] = nx[p];
      m_sel = nsel; m_id = nid;
      @(negedge clk);
      ok = 1'b1; badp = 0;
      for (int p = 0; p < NP; p++)
         if (entries[p*64 +: 64] !== m_ent[p]) begin ok = 1'b0; badp = p; end
      check(ok, "R11 entries", entries[badp*64 +: 64], m_ent[badp]);
      check(bus_rvalid === rd, "R9 rvalid", {63'b0, bus_rvalid}, {63'b0, rd});
      if (rd) begin
         last_rd = bus_rdata;
         check(bus_rdata === exp_rd, tag, {32'b0, bus_rdata}, {32'b0, exp_rd});
      end
      check(mask_chg === exp_chg, "R10 pulse", {63'b0, mask_chg}, {63'b0, exp_chg});
      if (exp_chg)
         check(int'(mask_pin) == exp_pin, "R10 pin", 64'(mask_pin), 64'(exp_pin));
   endtask

   task automatic wr_reg(input logic [7:0] a, input logic [31:0] d, input string tag);
      step(1'b1, 1'b0, a, d, '0, '0, ds_hold, tag);
   endtask

   task automatic rd_lit(input logic [7:0] a, input logic [31:0] lit, input string tag);
      step(1'b0, 1'b1, a, 32'h0, '0, '0, ds_hold, tag);
      check(last_rd === lit, tag, {32'b0, last_rd}, {32'b0, lit});
   endtask

   initial begin
      #(4 * 200000);
      bad++;
      total++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int p = 0; p < NP; p++) m_ent[p] = 64'h1 << 16;
      m_sel = '0; m_id = '0; last_rd = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R8 reset state
      check(entries[16] === 1'b1 && entries[15:0] === 16'h0, "R8 entry0 reset", entries[63:0], 64'h10000);
      rd_lit(SELA, 32'h0, "R8 select");
      rd_lit(WINA, 32'h0, "R8 identity");
      // R1 select width
      wr_reg(SELA, 32'h0000_01FF, "R1");
      rd_lit(SELA, 32'h0000_00FF, "R1 select low byte");
      // R2 version
      wr_reg(SELA, 32'h01, "R2");
      rd_lit(WINA, 32'h0017_0011, "R2 version");
      wr_reg(WINA, 32'hFFFF_FFFF, "R2");
      rd_lit(WINA, 32'h0017_0011, "R2 version after write");
      // R3 identity and arbitration
      wr_reg(SELA, 32'h00, "R3");
      wr_reg(WINA, 32'hA500_0000, "R3");
      rd_lit(WINA, 32'h0500_0000, "R3 identity");
      wr_reg(SELA, 32'h02, "R3");
      rd_lit(WINA, 32'h0500_0000, "R3 arbitration");
      wr_reg(WINA, 32'h0, "R3");
      wr_reg(SELA, 32'h00, "R3");
      rd_lit(WINA, 32'h0500_0000, "R3 arbitration write ignored");
      // R4 entry halves, pin 5
      wr_reg(SELA, 32'h1A, "R4");
      wr_reg(WINA, 32'h0000_A031, "R10 unmask");
      rd_lit(WINA, 32'h0000_A031, "R4 low half");
      wr_reg(SELA, 32'h1B, "R4");
      wr_reg(WINA, 32'hC300_0000, "R4");
      rd_lit(WINA, 32'hC300_0000, "R4 high half");
      check(entries[5*64 +: 64] === 64'hC300_0000_0000_A031, "R11 pin5", entries[5*64 +: 64], 64'hC300_0000_0000_A031);
      // R6 hardware-owned bits survive writes
      ds_hold = NP'(1) << 5;
      step(1'b0, 1'b0, SELA, 32'h0, NP'(1) << 5, '0, ds_hold, "R6");
      wr_reg(SELA, 32'h1A, "R6");
      wr_reg(WINA, 32'h0000_A031, "R6");
      rd_lit(WINA, 32'h0000_F031, "R6 rirr and dstat kept");
      // R7 edge clears remote IRR
      wr_reg(WINA, 32'h0000_2031, "R7");
      rd_lit(WINA, 32'h0000_3031, "R7 edge clears rirr");
      ds_hold = '0;
      // R4 last pin
      wr_reg(SELA, 32'h3E, "R4");
      wr_reg(WINA, 32'h0001_8055, "R4");
      rd_lit(WINA, 32'h0001_8055, "R4 last pin");
      // R5 out of range
      wr_reg(SELA, 32'h40, "R5");
      rd_lit(WINA, 32'hFFFF_FFFF, "R5 beyond last pin");
      wr_reg(WINA, 32'h0, "R5 write discarded");
      wr_reg(SELA, 32'h05, "R5");
      rd_lit(WINA, 32'hFFFF_FFFF, "R5 unused index");
      // R9 other offsets
      wr_reg(8'h08, 32'h1234_5678, "R9");
      rd_lit(8'h08, 32'h0, "R9 other offset reads zero");
      rd_lit(SELA, 32'h05, "R9 other offset write ignored");
      // random phase
      for (int n = 0; n < 800; n++) begin
         logic [7:0]  a;
         logic [31:0] d;
         int          pick;
         pick = int'($urandom % 8);
         a = (pick < 2) ? SELA : ((pick == 7) ? 8'h08 : WINA);
         d = $urandom;
         if (a == SELA) d = {$urandom, 8'h00} | (32'($urandom % 8'h44));
         step(1'($urandom), 1'($urandom), a, d,
              NP'($urandom & $urandom & $urandom), NP'($urandom & $urandom & $urandom),
              NP'($urandom), "R4 random read");
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule